// File: doc/BRIEF.md
# Internal Soft Reset Sequencer

This block produces the internal soft reset sequence on a shared, open-drain style soft-reset pin. Any of several internal sources, such as a boundary-scan controller or a debug port, may request a soft reset. The block then pulls the pin low for a fixed number of clock cycles. At the end of that interval it latches the two debug configuration inputs (serial data in and serial clock) and releases the pin to an external pull-up.

The pin is modelled as a drive-enable output plus a sensed-level input. After the release, the block waits until the synchronized pin level reads high. It then waits a guard period before it detects external soft resets again. While the sequence is active, the block ignores further internal requests and does not report lows on the pin. Once idle, each falling edge of the synchronized pin produces a one-cycle external soft-reset event.

Top module: `srst_seq`

## Requirements
- R1: After reset, pin_drive_o, active_o and ext_evt_o are 0 and dbg_cfg_o is 2'b00.
- R2: When idle, any bit of req_i sampled high at a clock edge sets pin_drive_o and active_o from that edge onward.
- R3: pin_drive_o stays high for exactly HOLD_CYCLES (default 512) consecutive cycles per sequence.
- R4: At the edge where pin_drive_o falls, dbg_cfg_o takes the pin values sampled at that edge. Bit 1 is dbg_sdi_i and bit 0 is dbg_sck_i. dbg_cfg_o then holds that value until the next release.
- R5: After the release, active_o stays high until the synchronized pin reads high, and then for GUARD_CYCLES (default 16) more cycles. Suppose the pin goes high h cycles after the release, with SYNC_STAGES=2. Then active_o is high for h + SYNC_STAGES + 1 + GUARD_CYCLES cycles after pin_drive_o falls.
- R6: Requests that arrive while active_o is high are ignored and do not restart or extend the sequence. A request after active_o falls starts a fresh full sequence.
- R7: No ext_evt_o pulse occurs while active_o is high. While idle, each high-to-low transition of the synchronized pin gives exactly one single-cycle ext_evt_o pulse, however long the low lasts.
- R8: active_o is high in every cycle in which pin_drive_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Internal soft-reset requests, one per source |
| pin_i | input | 1 | Sensed level of the soft-reset pin (low = asserted) |
| dbg_sdi_i | input | 1 | Debug serial data in configuration pin |
| dbg_sck_i | input | 1 | Debug serial clock configuration pin |
| pin_drive_o | output | 1 | When high, the pad pulls the soft-reset pin low |
| active_o | output | 1 | Internal soft reset sequence in progress |
| dbg_cfg_o | output | 2 | Debug configuration latched at release, {sdi, sck} |
| ext_evt_o | output | 1 | One-cycle external soft-reset event |

## Verification
The checker monitors several rules on every cycle:
- the drive interval never exceeds its length and ends at exactly that length;
- the configuration equals the pin values at the releasing edge;
- a new drive starts only from idle;
- every event pulse follows a synchronized high-to-low pin transition;
- the sequence ends only with the pin high.

Some behaviour only the bench scenarios can show. These cases are the length of the guard window when an external driver holds the pin low past the release, and the absence of events for lows inside the guard window. They also cover requests made mid-sequence being dropped, and exactly one event per idle low pulse.

// File: rtl/srst_pkg.sv
package srst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GUARD = 2'd3
  } srst_state_e;
endpackage

// File: rtl/srst_sync.sv
module srst_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     ff_q[g] <= RST_VAL;
        else if (g == 0) ff_q[g] <= d_i;
        else             ff_q[g] <= ff_q[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/srst_timer.sv
module srst_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int HOLD_CYCLES  = 512,
  parameter int GUARD_CYCLES = 16,
  parameter int W            = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_any_i,
  input  logic         pin_high_i,
  input  logic         tmr_zero_i,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output logic         tmr_en_o,
  output logic         capture_o,
  output srst_state_e  state_o
);
  localparam logic [W-1:0] HOLD_LD  = W'(HOLD_CYCLES - 1);
  localparam logic [W-1:0] GUARD_LD = W'(GUARD_CYCLES - 1);

  srst_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = HOLD_LD;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_any_i) begin
        state_d    = ST_DRIVE;
        tmr_load_o = 1'b1;
        tmr_val_o  = HOLD_LD;
      end
      ST_DRIVE: if (tmr_zero_i) begin
        state_d   = ST_WAIT;
        capture_o = 1'b1;
      end
      ST_WAIT: if (pin_high_i) begin
        state_d    = ST_GUARD;
        tmr_load_o = 1'b1;
        tmr_val_o  = GUARD_LD;
      end
      ST_GUARD: if (tmr_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_en_o = (state_q == ST_DRIVE) || (state_q == ST_GUARD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/srst_seq.sv
module srst_seq
  import srst_pkg::*;
#(
  parameter int N_REQ        = 2,
  parameter int HOLD_CYCLES  = 512,
  parameter int GUARD_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             pin_i,
  input  logic             dbg_sdi_i,
  input  logic             dbg_sck_i,
  output logic             pin_drive_o,
  output logic             active_o,
  output logic [1:0]       dbg_cfg_o,
  output logic             ext_evt_o
);
  localparam int MAXC  = (HOLD_CYCLES > GUARD_CYCLES) ? HOLD_CYCLES : GUARD_CYCLES;
  localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;

  logic             pin_s;
  logic             pin_s_q;
  logic             tmr_load, tmr_en, tmr_zero, capture;
  logic [CNT_W-1:0] tmr_val;
  srst_state_e      state;
  logic [1:0]       cfg_q;

  srst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  srst_timer #(.W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .en_i      (tmr_en),
    .zero_o    (tmr_zero)
  );

  srst_ctrl #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .GUARD_CYCLES(GUARD_CYCLES),
    .W           (CNT_W)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_any_i (|req_i),
    .pin_high_i(pin_s),
    .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .tmr_en_o  (tmr_en),
    .capture_o (capture),
    .state_o   (state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= 2'b00;
      pin_s_q <= 1'b1;
    end else begin
      pin_s_q <= pin_s;
      if (capture) cfg_q <= {dbg_sdi_i, dbg_sck_i};
    end
  end

  assign pin_drive_o = (state == ST_DRIVE);
  assign active_o    = (state != ST_IDLE);
  assign dbg_cfg_o   = cfg_q;
  // falling edge of synchronized pin, only outside a sequence
  assign ext_evt_o   = (state == ST_IDLE) && !pin_s && pin_s_q;
endmodule

// File: rtl/srst_seq_chk.sv
module srst_seq_chk #(
  parameter int N_REQ       = 2,
  parameter int HOLD_CYCLES = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_i,
  input logic             pin_i,
  input logic             dbg_sdi_i,
  input logic             dbg_sck_i,
  input logic             pin_drive_o,
  input logic             active_o,
  input logic [1:0]       dbg_cfg_o,
  input logic             ext_evt_o
);
  int unsigned drv_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          drv_cnt <= 0;
    else if (pin_drive_o) drv_cnt <= drv_cnt + 1;
    else                  drv_cnt <= 0;
  end

  assert_drive_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_cnt <= HOLD_CYCLES);

  assert_drive_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_o) |-> drv_cnt == HOLD_CYCLES);

  assert_cfg_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_o) |-> dbg_cfg_o == $past({dbg_sdi_i, dbg_sck_i}));

  assert_start_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_drive_o) |-> !$past(active_o));

  assert_evt_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_evt_o |-> (!$past(pin_i, 2) && $past(pin_i, 3)));

  assert_evt_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_evt_o |=> !ext_evt_o);

  assert_end_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(pin_i));

  assert_drive_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> active_o);
endmodule

bind srst_seq srst_seq_chk #(.N_REQ(N_REQ), .HOLD_CYCLES(HOLD_CYCLES)) i_srst_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .pin_i      (pin_i),
  .dbg_sdi_i  (dbg_sdi_i),
  .dbg_sck_i  (dbg_sck_i),
  .pin_drive_o(pin_drive_o),
  .active_o   (active_o),
  .dbg_cfg_o  (dbg_cfg_o),
  .ext_evt_o  (ext_evt_o)
);

// File: tb/test_srst_seq.sv
`timescale 1ns/1ps
module test_srst_seq;
  localparam int N_REQ = 2;
  localparam int HOLD  = 512;
  localparam int GUARD = 16;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_REQ-1:0] req = '0;
  logic             ext_low = 1'b0;
  logic             sdi = 1'b0, sck = 1'b0;
  logic             pin;
  logic             drive, active, evt;
  logic [1:0]       cfg;
  int               checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign pin = ~(drive | ext_low);

  srst_seq #(.N_REQ(N_REQ), .HOLD_CYCLES(HOLD), .GUARD_CYCLES(GUARD), .SYNC_STAGES(SYNC)) i_srst_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .pin_i(pin),
    .dbg_sdi_i(sdi), .dbg_sck_i(sck),
    .pin_drive_o(drive), .active_o(active), .dbg_cfg_o(cfg), .ext_evt_o(evt)
  );

  function automatic int exp_post(input int hold_low);
    return hold_low + SYNC + 1 + GUARD;
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic run_seq(input int src, input logic [1:0] c, input int hold_low, input bit poke);
    int dcnt, acnt, evts;
    sdi = c[1]; sck = c[0];
    @(negedge clk);
    req = '0; req[src] = 1'b1;
    @(negedge clk);
    req = '0;
    chk(drive && active, "R2", {drive, active}, 3);
    dcnt = 0;
    while (drive && dcnt < 2000) begin
      dcnt++;
      if (!active) chk(0, "R8", 0, 1);
      req = (poke && dcnt == 100) ? '1 : '0;
      @(negedge clk);
    end
    req = '0;
    chk(dcnt == HOLD, "R3", dcnt, HOLD);
    chk(cfg == c, "R4", cfg, c);
    acnt = 0; evts = 0;
    while (active && acnt < 2000) begin
      acnt++;
      if (evt) evts++;
      ext_low = (acnt <= hold_low) || (poke && acnt > hold_low + 4 && acnt < hold_low + 9);
      req = (poke && (acnt == 2 || acnt == hold_low + 6)) ? '1 : '0;
      @(negedge clk);
    end
    ext_low = 1'b0; req = '0;
    chk(acnt == exp_post(hold_low), "R5", acnt, exp_post(hold_low));
    chk(evts == 0, "R7", evts, 0);
    if (poke) chk(!drive && !active, "R6", {drive, active}, 0);
  endtask

  task automatic idle_pulse(input int len);
    int evts;
    evts = 0;
    for (int i = 0; i < len + 8; i++) begin
      ext_low = (i < len);
      @(negedge clk);
      if (evt) evts++;
    end
    ext_low = 1'b0;
    chk(evts == 1, "R7", evts, 1);
    chk(cfg == {sdi, sck}, "R4", cfg, {sdi, sck});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!drive && !active && !evt && cfg == 2'b00, "R1", {drive, active, evt, cfg}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!drive && !active && !evt && cfg == 2'b00, "R1", {drive, active, evt, cfg}, 0);

    run_seq(0, 2'b10, 0, 1'b0);
    run_seq(1, 2'b01, 0, 1'b1);   // back to back, fresh sequence (R6)
    run_seq(0, 2'b11, 25, 1'b0);  // external driver holds pin past release
    idle_pulse(1);
    idle_pulse(40);

    for (int k = 0; k < 8; k++) begin
      run_seq($urandom_range(N_REQ-1, 0), 2'($urandom_range(3, 0)),
              $urandom_range(12, 0), 1'($urandom_range(1, 0)));
      repeat ($urandom_range(5, 0)) @(negedge clk);
      idle_pulse($urandom_range(20, 1));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule